// File: doc/BRIEF.md
# Programmable Logic Output Macrocell Bank

This block is the output stage that sits behind the OR gates of a programmable sum-of-products array. Each cell takes one sum-of-products term. A two-bit mode decides whether the pin is driven from a D flip-flop or straight from the term, and whether the pin is active high or active low. A feedback multiplexer picks the signal that goes back into the AND plane. That signal is either the cell's own output, so that registered cells can be chained into state machines, or the level seen on the external pin.

Several cells sit side by side, each with its own configuration. The configuration is static. It is captured only while reset is active and is held for the rest of operation. An output-enable per cell tells the pad whether to drive. When the pad is not driving, the feedback path always takes the pin input.

Top module: `pld_mc_bank`

## Requirements
- R1: The 2-bit mode of a cell selects the pin function as follows: 2'b00 gives the inverted flip-flop value, 2'b01 gives the flip-flop value, 2'b10 gives the inverted sum-of-products input, and 2'b11 gives the sum-of-products input unchanged.
- R2: In the registered modes (mode bit 1 = 0), the pin changes only after a rising clock edge, and it reflects the sum-of-products value sampled at that edge. In the combinational modes (mode bit 1 = 1), the pin follows the input with no clock.
- R3: With the feedback select at 0, the feedback output carries the cell's internal signal. With the select at 1, it carries the external pin input.
- R4: The internal feedback of a registered cell is the flip-flop value taken before polarity inversion. The internal feedback of a combinational cell is the value driven on the pin.
- R5: The pin drive enable equals the cell's output-enable input. While output-enable is 0, the feedback output carries the external pin input whatever the feedback select says.
- R6: A low level on rst_n clears every flip-flop at once, without waiting for a clock edge. The flip-flops stay cleared until RST_STAGES rising edges (default 2) have passed after rst_n returns high.
- R7: Mode and feedback-select inputs are captured only on clock edges while reset is active. Changes to them after reset has been released have no effect on any output.
- R8: Each cell is configured independently of the others. Mode bits [2i+1:2i] and feedback-select bit i belong to cell i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output flip-flops |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_mode | input | 2*N_CELLS | Per-cell output mode, sampled during reset |
| cfg_fb_sel | input | N_CELLS | Per-cell feedback select, 0 internal, 1 pin, sampled during reset |
| sop_in | input | N_CELLS | Sum-of-products terms from the OR gates |
| oe_in | input | N_CELLS | Per-cell output enable |
| pin_in | input | N_CELLS | Level sensed on each external pin |
| pin_out | output | N_CELLS | Data driven toward each pin |
| pin_drive_en | output | N_CELLS | Pad drive enable, 0 means high impedance |
| fb_out | output | N_CELLS | Feedback returned to the AND plane |

## Verification
The bench builds the block with N_CELLS = 4 and RST_STAGES = 2. Four cells are enough to hold all four output modes at the same time, which puts cross-cell independence within reach. Two synchronizer stages make the exact release edge of the flip-flop clear observable within a few cycles. The vector table covers every mode with both input levels, both feedback selects and a disabled pad. Directed cases then cover the asynchronous clear, the one-cycle register delay, and configuration changes made after release.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

  typedef enum logic [1:0] {
    MC_REG_LOW   = 2'b00,
    MC_REG_HIGH  = 2'b01,
    MC_COMB_LOW  = 2'b10,
    MC_COMB_HIGH = 2'b11
  } mc_mode_e;

  localparam logic FB_INTERNAL = 1'b0;
  localparam logic FB_PIN      = 1'b1;

  function automatic logic mode_is_registered(input mc_mode_e m);
    return (m == MC_REG_LOW) || (m == MC_REG_HIGH);
  endfunction

endpackage

// File: rtl/pld_mc_rst_sync.sv
module pld_mc_rst_sync #(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_active
);

  localparam int TOP = RST_STAGES - 1;

  logic [TOP:0] sync_q;
  logic [TOP:0] sync_d;

  always_comb begin
    sync_d = {sync_q[TOP-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_active = ~sync_q[TOP];

endmodule

// File: rtl/pld_mc_cfg.sv
module pld_mc_cfg #(
  parameter int N_CELLS = 4
) (
  input  logic                   clk,
  input  logic                   rst_active,
  input  logic [2*N_CELLS-1:0]   cfg_mode,
  input  logic [N_CELLS-1:0]     cfg_fb_sel,
  output logic [2*N_CELLS-1:0]   mode_q,
  output logic [N_CELLS-1:0]     fb_sel_q
);

  logic [2*N_CELLS-1:0] mode_d;
  logic [N_CELLS-1:0]   fb_sel_d;

  always_comb begin
    mode_d   = mode_q;
    fb_sel_d = fb_sel_q;
    if (rst_active) begin
      mode_d   = cfg_mode;
      fb_sel_d = cfg_fb_sel;
    end
  end

  always_ff @(posedge clk) begin
    mode_q   <= mode_d;
    fb_sel_q <= fb_sel_d;
  end

endmodule

// File: rtl/pld_mc_cell.sv
module pld_mc_cell
  import pld_mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_active,
  input  logic [1:0] mode,
  input  logic       fb_sel,
  input  logic       sop,
  input  logic       oe,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       drive_en,
  output logic       fb
);

  mc_mode_e mode_e;
  logic     reg_en;
  logic     q;
  logic     q_d;
  logic     internal_fb;

  assign mode_e = mc_mode_e'(mode);
  assign reg_en = mode_is_registered(mode_e);

  always_comb begin
    q_d = q;
    if (rst_active)  q_d = 1'b0;
    else if (reg_en) q_d = sop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  always_comb begin
    case (mode_e)
      MC_REG_LOW:   pin_out = ~q;
      MC_REG_HIGH:  pin_out = q;
      MC_COMB_LOW:  pin_out = ~sop;
      MC_COMB_HIGH: pin_out = sop;
      default:      pin_out = sop;
    endcase
  end

  always_comb begin
    internal_fb = reg_en ? q : pin_out;
    if ((fb_sel == FB_PIN) || !oe) fb = pin_in;
    else                           fb = internal_fb;
  end

  assign drive_en = oe;

endmodule

// File: rtl/pld_mc_bank.sv
module pld_mc_bank #(
  parameter int N_CELLS    = 4,
  parameter int RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*N_CELLS-1:0] cfg_mode,
  input  logic [N_CELLS-1:0]   cfg_fb_sel,
  input  logic [N_CELLS-1:0]   sop_in,
  input  logic [N_CELLS-1:0]   oe_in,
  input  logic [N_CELLS-1:0]   pin_in,
  output logic [N_CELLS-1:0]   pin_out,
  output logic [N_CELLS-1:0]   pin_drive_en,
  output logic [N_CELLS-1:0]   fb_out
);

  logic                 rst_active;
  logic [2*N_CELLS-1:0] mode_q;
  logic [N_CELLS-1:0]   fb_sel_q;

  pld_mc_rst_sync #(.RST_STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_active (rst_active)
  );

  pld_mc_cfg #(.N_CELLS(N_CELLS)) u_cfg (
    .clk        (clk),
    .rst_active (rst_active),
    .cfg_mode   (cfg_mode),
    .cfg_fb_sel (cfg_fb_sel),
    .mode_q     (mode_q),
    .fb_sel_q   (fb_sel_q)
  );

  for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_cell
    pld_mc_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_active (rst_active),
      .mode       (mode_q[2*gi +: 2]),
      .fb_sel     (fb_sel_q[gi]),
      .sop        (sop_in[gi]),
      .oe         (oe_in[gi]),
      .pin_in     (pin_in[gi]),
      .pin_out    (pin_out[gi]),
      .drive_en   (pin_drive_en[gi]),
      .fb         (fb_out[gi])
    );
  end

endmodule

// File: rtl/pld_mc_checker.sv
module pld_mc_checker #(
  parameter int N_CELLS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_active,
  input logic [2*N_CELLS-1:0] mode_q,
  input logic [N_CELLS-1:0]   fb_sel_q,
  input logic [N_CELLS-1:0]   sop_in,
  input logic [N_CELLS-1:0]   oe_in,
  input logic [N_CELLS-1:0]   pin_in,
  input logic [N_CELLS-1:0]   pin_out,
  input logic [N_CELLS-1:0]   pin_drive_en,
  input logic [N_CELLS-1:0]   fb_out
);

  // set when the previous edge was taken outside reset
  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= !rst_active;
  end

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !rst_active |=> $stable(mode_q) && $stable(fb_sel_q));

  for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_chk
    assert_reg_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
      live_q && !rst_active && !mode_q[2*gi+1]
      |-> pin_out[gi] == ($past(sop_in[gi]) ^ !mode_q[2*gi]));

    assert_pin_fb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_active && fb_sel_q[gi] |-> fb_out[gi] == pin_in[gi]);

    assert_comb_fb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_active && oe_in[gi] && !fb_sel_q[gi] && mode_q[2*gi+1]
      |-> fb_out[gi] == pin_out[gi]);

    assert_oe_fb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_in[gi] |-> fb_out[gi] == pin_in[gi] && pin_drive_en[gi] == oe_in[gi]);

    assert_reset_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_active |=> mode_q[2*gi+1] || (pin_out[gi] == !mode_q[2*gi]));
  end

endmodule

bind pld_mc_bank pld_mc_checker #(.N_CELLS(N_CELLS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_active   (rst_active),
  .mode_q       (mode_q),
  .fb_sel_q     (fb_sel_q),
  .sop_in       (sop_in),
  .oe_in        (oe_in),
  .pin_in       (pin_in),
  .pin_out      (pin_out),
  .pin_drive_en (pin_drive_en),
  .fb_out       (fb_out)
);

// File: tb/sim_pld_mc_bank.sv
module sim_pld_mc_bank;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  // {mode[1:0], fb_sel, oe, sop, pin, exp_out, exp_fb}
  localparam logic [7:0] VEC [12] = '{
    8'b00_0_1_1_0_0_1, 8'b00_0_1_0_1_1_0,
    8'b01_0_1_1_0_1_1, 8'b01_0_1_0_1_0_0,
    8'b10_0_1_1_0_0_0, 8'b10_0_1_0_1_1_1,
    8'b11_0_1_1_0_1_1, 8'b11_0_1_0_1_0_0,
    8'b01_1_1_1_0_1_0, 8'b10_1_1_0_0_1_0,
    8'b11_0_0_1_0_1_0, 8'b00_0_0_0_1_1_1
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic [2*N-1:0] cfg_mode;
  logic [N-1:0]   cfg_fb_sel, sop_in, oe_in, pin_in;
  logic [N-1:0]   pin_out, pin_drive_en, fb_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pld_mc_bank #(.N_CELLS(N), .RST_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_fb_sel(cfg_fb_sel),
    .sop_in(sop_in), .oe_in(oe_in), .pin_in(pin_in),
    .pin_out(pin_out), .pin_drive_en(pin_drive_en), .fb_out(fb_out)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic configure(input logic [2*N-1:0] m, input logic [N-1:0] fs);
    @(posedge clk); #1;
    rst_n = 1'b0; cfg_mode = m; cfg_fb_sel = fs;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_mode = '0; cfg_fb_sel = '0;
    sop_in = '1; oe_in = '1; pin_in = '0;
    repeat (3) @(posedge clk); #1;
    // R6: flip-flop clear during reset, mode 00 shows inverted zero
    check("R6 reset state low-active", pin_out, 4'b1111);
    cfg_mode = {N{2'b01}};
    repeat (2) @(posedge clk); #1;
    check("R6 reset state high-active", pin_out, 4'b0000);

    // vector table: R1 output, R3/R4/R5 feedback, R5 drive enable
    for (int i = 0; i < 12; i++) begin
      configure({N{VEC[i][7:6]}}, {N{VEC[i][5]}});
      oe_in = {N{VEC[i][4]}}; sop_in = {N{VEC[i][3]}}; pin_in = {N{VEC[i][2]}};
      @(posedge clk); #1;
      check($sformatf("R1 vec%0d pin", i), pin_out, {N{VEC[i][1]}});
      check($sformatf("R3/R4/R5 vec%0d fb", i), fb_out, {N{VEC[i][0]}});
      check($sformatf("R5 vec%0d drive", i), pin_drive_en, {N{VEC[i][4]}});
    end

    // R2: registered delay versus combinational follow
    configure({N{2'b01}}, '0);
    oe_in = '1; sop_in = '0; pin_in = '0;
    @(posedge clk); #1;
    sop_in = '1; #1;
    check("R2 registered holds before edge", pin_out, 4'b0000);
    @(posedge clk); #1;
    check("R2 registered after edge", pin_out, 4'b1111);
    configure({N{2'b11}}, '0);
    sop_in = '0; #1;
    check("R2 combinational follows", pin_out, 4'b0000);
    sop_in = '1; #1;
    check("R2 combinational follows high", pin_out, 4'b1111);

    // R7: configuration changes after release are ignored
    configure({N{2'b01}}, '0);
    sop_in = '1;
    @(posedge clk); #1;
    cfg_mode = {N{2'b10}}; cfg_fb_sel = '1; sop_in = '0; pin_in = '0; #1;
    check("R7 mode ignored pin", pin_out, 4'b1111);
    check("R7 fb_sel ignored fb", fb_out, 4'b1111);
    @(posedge clk); #1;
    check("R7 still registered", pin_out, 4'b0000);

    // R6: asynchronous clear and release timing
    sop_in = '1;
    @(posedge clk); #1;
    check("R6 precondition", pin_out, 4'b1111);
    cfg_mode = {N{2'b01}}; cfg_fb_sel = '0;
    rst_n = 1'b0; #1;
    check("R6 async clear", pin_out, 4'b0000);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R6 held after first edge", pin_out, 4'b0000);
    @(posedge clk); #1;
    check("R6 held after second edge", pin_out, 4'b0000);
    @(posedge clk); #1;
    check("R6 released", pin_out, 4'b1111);

    // R8: each cell its own mode (cell3=11, cell2=10, cell1=01, cell0=00)
    configure(8'b11_10_01_00, 4'b0000);
    oe_in = '1; sop_in = '1; pin_in = '0;
    @(posedge clk); #1;
    check("R8 mixed modes pin", pin_out, 4'b1010);
    check("R8 mixed modes fb", fb_out, 4'b1011);
    configure(8'b01_01_01_01, 4'b0101);
    pin_in = '0; sop_in = '1;
    @(posedge clk); #1;
    check("R8 mixed fb select", fb_out, 4'b1010);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule